// File: doc/BRIEF.md
# Clock Buffer Power-Up Sequencer

This block decides when a bank of differential clock outputs may be switched on after the board powers up. It runs from a free-running system clock. It watches five inputs: a supply-good indication, an active-low power-down request, the raw reference clock, a PLL lock flag and a PLL-bypass strap. It then steps through four states: off, a fixed settling delay, a wait for a usable reference, and normal running. Only the last of these drives a registered output-enable.

The sequencer decides for itself whether the reference is live. It passes the reference through a two-flop synchroniser and counts its rising edges over a fixed window of system-clock cycles. Two counters are measured in system-clock ticks: one sets the settling delay, the other sets the deadline for reaching normal running. A loss of supply returns the block to the off state from anywhere. Defaults assume a 100 MHz system clock: a 0.25 ms delay, a 1 ms deadline, and a 64-cycle window that needs 4 edges.

Top module: `clkbuf_pwrup_seq`

## Requirements
- R1: While reset is held and after it is released with supply low, state_o reads 0 (OFF), out_en_o is 0 and timeout_o is 0. State codes are OFF=0, DELAY=1, WAIT=2, RUN=3.
- R2: From OFF with supply_ok_i high, state_o becomes DELAY (1) on the next edge. It stays DELAY for exactly DELAY_TICKS cycles and then becomes WAIT (2).
- R3: In WAIT, if the reference clock is not detected as active, state_o stays WAIT and out_en_o stays 0, even with power-down released and the PLL locked.
- R4: WAIT moves to RUN only when all four conditions hold: pwrdn_ni is high, the reference is active, supply is good, and either pll_locked_i or pll_bypass_i is high. With bypass low and lock low the state stays WAIT.
- R5: With pll_bypass_i high, pll_locked_i has no effect: WAIT moves to RUN with lock low.
- R6: In RUN, pwrdn_ni low moves state_o to WAIT and clears out_en_o on the next edge.
- R7: supply_ok_i low in any state moves state_o to OFF and clears out_en_o and timeout_o, all on the same next edge.
- R8: timeout_o rises TIMEOUT_TICKS edges after state_o first shows DELAY if RUN has not been shown before that edge. Reaching RUN on that same edge still raises it; reaching RUN one edge earlier does not. Once high, it stays high until supply is lost.
- R9: The reference counts as active when at least MIN_EDGES synchronised rising edges fall in one window of WIN_CYCLES cycles. A reference with fewer edges per window does not count as active.
- R10: out_en_o is 1 exactly when state_o is RUN (3). It changes only on the edge where state_o changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| supply_ok_i | input | 1 | Supply-good indication from the analog detector |
| pwrdn_ni | input | 1 | Power-down request, active low |
| ref_clk_i | input | 1 | Raw reference clock, asynchronous to clk_i |
| pll_locked_i | input | 1 | PLL lock flag |
| pll_bypass_i | input | 1 | PLL bypass strap, 1 = bypass |
| out_en_o | output | 1 | Registered enable for the clock outputs |
| state_o | output | 2 | Current sequencer state (0 OFF, 1 DELAY, 2 WAIT, 3 RUN) |
| timeout_o | output | 1 | Deadline for reaching RUN was missed |

## Verification
The deadline counter and the WAIT-to-RUN transition can resolve on the same edge. The bench provokes this by holding lock low until exactly the cycle before the TIMEOUT_TICKS-th edge after DELAY begins. It expects both RUN and a raised timeout there. It then repeats the sequence with lock raised one cycle earlier and expects RUN with no timeout. A second pair to meet on one edge is supply loss and power-down while in RUN. Here supply loss has priority, and this is judged by the state going to OFF and not to WAIT.

// File: rtl/clkbuf_pwrup_pkg.sv
// Package: shared state encoding for the power-up sequencer.
// Assumes: state codes are visible at the top port and must stay fixed.
package clkbuf_pwrup_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF   = 2'd0,
        SEQ_DELAY = 2'd1,
        SEQ_WAIT  = 2'd2,
        SEQ_RUN   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/refclk_activity.sv
// Module: refclk_activity
// Synchronises an asynchronous reference clock and declares it active when
// at least MIN_EDGES rising edges are seen within a window of WIN_CYCLES
// system-clock cycles. The verdict is refreshed once per window.
// Assumes: the reference toggles slower than half the system clock rate.
module refclk_activity #(
    parameter int WIN_CYCLES  = 64,
    parameter int MIN_EDGES   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_clk_i,
    output logic active_o
);
    localparam int WW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam int EW = $clog2(MIN_EDGES + 1);

    logic [SYNC_STAGES:0] sync_q;
    logic [WW-1:0]        win_q;
    logic [EW-1:0]        edge_q;
    logic [EW-1:0]        edge_nxt;
    logic                 rise;
    logic                 win_end;

    // Purpose: synchroniser chain plus one extra stage for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-1:0], ref_clk_i};
    end

    // Purpose: decode a synchronised rising edge, window end and saturating count.
    always_comb begin
        rise     = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
        win_end  = (win_q == WW'(WIN_CYCLES - 1));
        edge_nxt = edge_q;
        if (rise && (edge_q != EW'(MIN_EDGES))) edge_nxt = edge_q + 1'b1;
    end

    // Purpose: advance the window and publish the verdict at its end.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            win_q    <= '0;
            edge_q   <= '0;
            active_o <= 1'b0;
        end else if (win_end) begin
            win_q    <= '0;
            edge_q   <= '0;
            active_o <= (edge_nxt == EW'(MIN_EDGES));
        end else begin
            win_q    <= win_q + 1'b1;
            edge_q   <= edge_nxt;
        end
    end

endmodule

// File: rtl/seq_tick_timer.sv
// Module: seq_tick_timer
// Counts system-clock ticks while run_i is high and flags the tick that
// completes LIMIT counted cycles. clear_i has priority and restarts at zero.
// Assumes: the owner stops or clears the timer once hit_o has been seen.
module seq_tick_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic run_i,
    output logic hit_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Purpose: flag the last counted cycle of the interval.
    assign hit_o = run_i && !clear_i && (cnt_q == CW'(LIMIT - 1));

    // Purpose: tick counter with priority clear.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clear_i) cnt_q <= '0;
        else if (run_i)         cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/seq_fsm.sv
// Module: seq_fsm
// Four-state power-up controller with a registered output-enable and a
// sticky deadline flag. Supply loss wins over every other condition.
// Assumes: delay_done_i and deadline_hit_i come from timers run by the top.
module seq_fsm
    import clkbuf_pwrup_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       supply_ok_i,
    input  logic       pwrdn_ni,
    input  logic       ref_ok_i,
    input  logic       pll_locked_i,
    input  logic       pll_bypass_i,
    input  logic       delay_done_i,
    input  logic       deadline_hit_i,
    output seq_state_e state_o,
    output logic       out_en_o,
    output logic       reached_o,
    output logic       timeout_o
);
    seq_state_e nxt;
    logic       start_ok;

    // Purpose: combine the conditions that permit driving the outputs.
    assign start_ok = pwrdn_ni && ref_ok_i && (pll_locked_i || pll_bypass_i);

    // Purpose: next-state decode, supply loss first.
    always_comb begin
        nxt = state_o;
        if (!supply_ok_i) begin
            nxt = SEQ_OFF;
        end else begin
            unique case (state_o)
                SEQ_OFF:   nxt = SEQ_DELAY;
                SEQ_DELAY: if (delay_done_i) nxt = SEQ_WAIT;
                SEQ_WAIT:  if (start_ok)     nxt = SEQ_RUN;
                SEQ_RUN:   if (!pwrdn_ni)    nxt = SEQ_WAIT;
                default:   nxt = SEQ_OFF;
            endcase
        end
    end

    // Purpose: state and output-enable registered from the same decision.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_o  <= SEQ_OFF;
            out_en_o <= 1'b0;
        end else begin
            state_o  <= nxt;
            out_en_o <= (nxt == SEQ_RUN);
        end
    end

    // Purpose: remember first arrival in RUN and latch a missed deadline.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !supply_ok_i || state_o == SEQ_OFF) begin
            reached_o <= 1'b0;
            timeout_o <= 1'b0;
        end else begin
            if (state_o == SEQ_RUN) reached_o <= 1'b1;
            if (deadline_hit_i)     timeout_o <= 1'b1;
        end
    end

endmodule

// File: rtl/clkbuf_pwrup_seq.sv
// Module: clkbuf_pwrup_seq (top)
// Power-up sequencer for a clock buffer: settling delay after supply-good,
// reference activity detection, lock/bypass gating and a deadline flag.
// Assumes: clk_i is free running; all timings are in clk_i ticks.
module clkbuf_pwrup_seq #(
    parameter int DELAY_TICKS   = 25000,
    parameter int TIMEOUT_TICKS = 100000,
    parameter int WIN_CYCLES    = 64,
    parameter int MIN_EDGES     = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       supply_ok_i,
    input  logic       pwrdn_ni,
    input  logic       ref_clk_i,
    input  logic       pll_locked_i,
    input  logic       pll_bypass_i,
    output logic       out_en_o,
    output logic [1:0] state_o,
    output logic       timeout_o
);
    import clkbuf_pwrup_pkg::*;

    seq_state_e st;
    logic       ref_ok;
    logic       delay_done;
    logic       deadline_hit;
    logic       reached;
    logic       dl_clear;
    logic       dl_run;

    // Purpose: deadline timer runs from leaving OFF until RUN or expiry.
    assign dl_clear = !supply_ok_i || (st == SEQ_OFF);
    assign dl_run   = (st != SEQ_RUN) && !reached && !timeout_o;
    assign state_o  = st;

    refclk_activity #(
        .WIN_CYCLES (WIN_CYCLES),
        .MIN_EDGES  (MIN_EDGES),
        .SYNC_STAGES(2)
    ) u_refdet (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ref_clk_i(ref_clk_i),
        .active_o (ref_ok)
    );

    seq_tick_timer #(.LIMIT(DELAY_TICKS)) u_delay (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clear_i(st != SEQ_DELAY),
        .run_i  (st == SEQ_DELAY),
        .hit_o  (delay_done)
    );

    seq_tick_timer #(.LIMIT(TIMEOUT_TICKS)) u_deadline (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clear_i(dl_clear),
        .run_i  (dl_run),
        .hit_o  (deadline_hit)
    );

    seq_fsm u_fsm (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .supply_ok_i   (supply_ok_i),
        .pwrdn_ni      (pwrdn_ni),
        .ref_ok_i      (ref_ok),
        .pll_locked_i  (pll_locked_i),
        .pll_bypass_i  (pll_bypass_i),
        .delay_done_i  (delay_done),
        .deadline_hit_i(deadline_hit),
        .state_o       (st),
        .out_en_o      (out_en_o),
        .reached_o     (reached),
        .timeout_o     (timeout_o)
    );

endmodule

// Module: clkbuf_pwrup_seq_chk
// Protocol checker bound to the sequencer top; observes only.
module clkbuf_pwrup_seq_chk #(
    parameter int DELAY_TICKS = 25000
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       supply_ok_i,
    input logic       pwrdn_ni,
    input logic       pll_locked_i,
    input logic       pll_bypass_i,
    input logic       ref_ok,
    input logic [1:0] state_o,
    input logic       out_en_o,
    input logic       timeout_o
);
    logic [31:0] dly_len;

    // Purpose: measure how long the DELAY state has been held.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)              dly_len <= '0;
        else if (state_o == 2'd1) dly_len <= dly_len + 1;
        else                      dly_len <= '0;
    end

    // R2
    off_to_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd0 && supply_ok_i) |=> state_o == 2'd1);
    // R2
    delay_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd2 && $past(state_o) == 2'd1) |-> dly_len == 32'(DELAY_TICKS));
    // R3
    no_ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd2 && !ref_ok) |=> state_o != 2'd3);
    // R4
    lock_needed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd2 && !pll_locked_i && !pll_bypass_i) |=> state_o != 2'd3);
    // R5
    bypass_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd2 && supply_ok_i && pwrdn_ni && ref_ok && pll_bypass_i)
        |=> state_o == 2'd3);
    // R6
    pwrdn_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd3 && supply_ok_i && !pwrdn_ni) |=> (state_o == 2'd2 && !out_en_o));
    // R7
    supply_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !supply_ok_i |=> (state_o == 2'd0 && !out_en_o && !timeout_o));
    // R8
    timeout_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (timeout_o && supply_ok_i) |=> timeout_o);
    // R10
    en_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_en_o == (state_o == 2'd3));
    // R10
    en_with_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(out_en_o) |-> !$stable(state_o));

endmodule

bind clkbuf_pwrup_seq clkbuf_pwrup_seq_chk #(.DELAY_TICKS(DELAY_TICKS)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .pwrdn_ni    (pwrdn_ni),
    .pll_locked_i(pll_locked_i),
    .pll_bypass_i(pll_bypass_i),
    .ref_ok      (ref_ok),
    .state_o     (state_o),
    .out_en_o    (out_en_o),
    .timeout_o   (timeout_o)
);

// File: tb/test_clkbuf_pwrup_seq.sv
`timescale 1ns/1ps
module test_clkbuf_pwrup_seq;
    localparam int DT  = 20;
    localparam int TO  = 200;
    localparam int WIN = 16;
    localparam int ME  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply = 1'b0;
    logic       pwrdn_n = 1'b1;
    logic       ref_clk = 1'b0;
    logic       lock = 1'b0;
    logic       bypass = 1'b0;
    logic       out_en;
    logic [1:0] state;
    logic       tmo;

    bit         ref_run = 1'b1;
    realtime    ref_half = 10.0;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;
    int         exp_q[$];
    logic [1:0] last_st = 2'd0;
    logic       last_en = 1'b0;

    clkbuf_pwrup_seq #(
        .DELAY_TICKS(DT), .TIMEOUT_TICKS(TO), .WIN_CYCLES(WIN), .MIN_EDGES(ME)
    ) i_clkbuf_pwrup_seq (
        .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply), .pwrdn_ni(pwrdn_n),
        .ref_clk_i(ref_clk), .pll_locked_i(lock), .pll_bypass_i(bypass),
        .out_en_o(out_en), .state_o(state), .timeout_o(tmo)
    );

    always #2.5 clk = ~clk;

    always begin
        #(ref_half);
        if (ref_run) ref_clk = ~ref_clk;
    end

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver side of the scoreboard: expected state transitions.
    task automatic push(input int s);
        exp_q.push_back(s);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops an expected state at every observed change.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (state != last_st) begin
                if (exp_q.size() == 0) chk_eq("R2 unexpected state change", int'(state), -1);
                else chk_eq("R2 state sequence", int'(state), exp_q.pop_front());
                chk_eq("R10 out_en vs state", int'(out_en), int'(state == 2'd3));
            end else if (out_en != last_en) begin
                chk_eq("R10 out_en changed without state", int'(out_en), int'(last_en));
            end
            last_st = state;
            last_en = out_en;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cycles(4);
        chk_eq("R1 state in reset", int'(state), 0);
        chk_eq("R1 out_en in reset", int'(out_en), 0);
        rst_n = 1'b1;
        cycles(3);
        chk_eq("R1 state after reset", int'(state), 0);
        chk_eq("R1 timeout after reset", int'(tmo), 0);

        // R2 delay length, R4 lock needed
        push(1); push(2);
        supply = 1'b1;
        @(negedge clk);
        chk_eq("R2 enter DELAY", int'(state), 1);
        begin
            int n = 0;
            while (state == 2'd1 && n < 200) begin n++; @(negedge clk); end
            chk_eq("R2 delay length", n, DT);
        end
        cycles(60);
        chk_eq("R4 no lock stays WAIT", int'(state), 2);
        push(3);
        lock = 1'b1;
        cycles(2);
        chk_eq("R4 lock enters RUN", int'(state), 3);
        chk_eq("R10 out_en in RUN", int'(out_en), 1);
        chk_eq("R8 no timeout when early", int'(tmo), 0);

        // R6 power-down from RUN
        push(2);
        pwrdn_n = 1'b0;
        @(negedge clk);
        chk_eq("R6 power-down to WAIT", int'(state), 2);
        chk_eq("R6 out_en cleared", int'(out_en), 0);
        cycles(30);
        chk_eq("R4 held in WAIT by power-down", int'(state), 2);
        push(3);
        pwrdn_n = 1'b1;
        cycles(2);
        chk_eq("R4 release to RUN", int'(state), 3);

        // R3 lost reference, R9 slow reference
        ref_run = 1'b0;
        cycles(3 * WIN + 8);
        push(2);
        pwrdn_n = 1'b0;
        cycles(2);
        pwrdn_n = 1'b1;
        cycles(60);
        chk_eq("R3 no reference stays WAIT", int'(state), 2);
        chk_eq("R3 out_en off without reference", int'(out_en), 0);
        ref_half = 20.0;
        ref_run = 1'b1;
        cycles(6 * WIN);
        chk_eq("R9 too few edges stays WAIT", int'(state), 2);
        push(3);
        ref_half = 10.0;
        cycles(4 * WIN);
        chk_eq("R9 enough edges enters RUN", int'(state), 3);

        // R7 supply loss from RUN collides with power-down
        push(0);
        supply = 1'b0;
        pwrdn_n = 1'b0;
        @(negedge clk);
        chk_eq("R7 supply loss beats power-down", int'(state), 0);
        chk_eq("R7 out_en cleared", int'(out_en), 0);
        pwrdn_n = 1'b1;
        lock = 1'b0;

        // R7 supply loss from DELAY
        push(1); push(0);
        supply = 1'b1;
        cycles(5);
        supply = 1'b0;
        @(negedge clk);
        chk_eq("R7 supply loss in DELAY", int'(state), 0);

        // R8 timeout expiry in WAIT
        push(1); push(2);
        supply = 1'b1;
        @(posedge clk);
        repeat (TO - 1) @(posedge clk);
        @(negedge clk);
        chk_eq("R8 timeout not yet", int'(tmo), 0);
        @(posedge clk);
        @(negedge clk);
        chk_eq("R8 timeout raised", int'(tmo), 1);
        cycles(10);
        chk_eq("R8 timeout sticky", int'(tmo), 1);
        push(0);
        supply = 1'b0;
        @(negedge clk);
        chk_eq("R7 timeout cleared by supply loss", int'(tmo), 0);

        // R8 late boundary: RUN on the deadline edge
        push(1); push(2); push(3);
        supply = 1'b1;
        @(posedge clk);
        repeat (TO - 1) @(posedge clk);
        @(negedge clk);
        lock = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk_eq("R8 late RUN state", int'(state), 3);
        chk_eq("R8 late RUN timeout", int'(tmo), 1);
        push(0);
        supply = 1'b0;
        lock = 1'b0;
        cycles(2);

        // R8 early boundary: RUN one edge before the deadline
        push(1); push(2); push(3);
        supply = 1'b1;
        @(posedge clk);
        repeat (TO - 2) @(posedge clk);
        @(negedge clk);
        lock = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk_eq("R8 early RUN state", int'(state), 3);
        cycles(20);
        chk_eq("R8 early RUN no timeout", int'(tmo), 0);

        // R5 bypass ignores lock
        push(0);
        supply = 1'b0;
        lock = 1'b0;
        bypass = 1'b1;
        cycles(2);
        push(1); push(2); push(3);
        supply = 1'b1;
        cycles(DT + 50);
        chk_eq("R5 bypass RUN without lock", int'(state), 3);
        chk_eq("R5 bypass out_en", int'(out_en), 1);

        cycles(2);
        chk_eq("R2 all expected transitions seen", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule